// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

A purely combinational integer ALU for a simple load/store processor datapath. Two operand words and a 4-bit operation selector go in; a result word, a zero flag and a signed-overflow flag come out in the same cycle. The unit handles addition and subtraction in signed and unsigned flavours, four bitwise logic functions, and signed and unsigned less-than comparison. Any sign or zero extension of immediates is done by the surrounding datapath before the operands arrive.

Internally the unit is a row of identical bit cells. Each cell has a full adder on a ripple carry chain and a small multiplexer that picks the adder sum, one of the logic functions, or the comparison bit. Subtraction reuses the adder by inverting the second operand and injecting a carry of one at the bottom of the chain. The overflow flag is only a flag: it raises no trap, and the control logic around the unit decides what to do with it.

Top module: `int_alu`

## Requirements
- R1: Selector 0x0 (signed add) and 0x1 (unsigned add) give res = opa + opb modulo 2^WIDTH.
- R2: Selector 0x2 (signed subtract) and 0x3 (unsigned subtract) give res = opa - opb modulo 2^WIDTH.
- R3: For selector 0x0, ovf is 1 exactly when opa and opb have equal sign bits and res has a different sign bit. For selector 0x2, ovf is 1 exactly when opa and opb have different sign bits and the sign bit of res differs from that of opa.
- R4: ovf is 0 for every selector other than 0x0 and 0x2, including unsigned add and subtract, logic and comparisons.
- R5: Selectors 0x4, 0x5, 0x6 and 0x7 give bitwise AND, OR, XOR and NOR of opa and opb.
- R6: Selector 0xA gives res bit 0 = 1 when opa < opb as two's complement numbers, and all other bits 0. The answer is correct even when opa - opb overflows.
- R7: Selector 0xB gives res bit 0 = 1 when opa < opb as unsigned numbers, and all other bits 0.
- R8: zero is 1 exactly when every bit of res is 0. In particular, with subtraction it is 1 exactly when opa equals opb.
- R9: Selectors 0x8, 0x9 and 0xC to 0xF give res = 0 and ovf = 0, so zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input  | WIDTH | First operand |
| opb  | input  | WIDTH | Second operand |
| op   | input  | 4     | Operation selector |
| res  | output | WIDTH | Result word |
| zero | output | 1     | Result is all zeros |
| ovf  | output | 1     | Signed overflow of add or subtract |

## Verification
Operands at the signed extremes (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 0 and 1) are applied with every selector. They tell signed from unsigned comparison, show overflow that is gated by the selector, and show a slt whose difference overflows, where the raw sign bit would give the wrong answer. Equal operands under subtraction separate a correct zero flag from one tied to the carry. Logic selectors with complementary patterns such as 0xAAAAAAAA and 0x55555555 separate AND, OR, XOR and NOR from one another. A long stream of random operands and selectors, including the unused codes, checks the ripple chain across many carry patterns.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] res,
  output logic             zero,
  output logic             ovf
);
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_ADDU = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_SUBU = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_XOR  = 4'h6;
  localparam logic [3:0] OP_NOR  = 4'h7;
  localparam logic [3:0] OP_SLT  = 4'hA;
  localparam logic [3:0] OP_SLTU = 4'hB;
  localparam int         MSB     = WIDTH - 1;

  logic             sub_mode;
  logic [WIDTH-1:0] b_in;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   carry;
  logic             ovf_raw;
  logic             less_s;
  logic             less_u;
  logic             set_bit;

  assign sub_mode = (op == OP_SUB) | (op == OP_SUBU) | (op == OP_SLT) | (op == OP_SLTU);
  assign b_in     = opb ^ {WIDTH{sub_mode}};
  assign carry[0] = sub_mode;

  genvar i;
  for (i = 0; i < WIDTH; i++) begin : g_cell
    logic y;
    logic lt_in;
    assign sum[i]     = opa[i] ^ b_in[i] ^ carry[i];
    assign carry[i+1] = (opa[i] & b_in[i]) | (opa[i] & carry[i]) | (b_in[i] & carry[i]);
    if (i == 0) begin : g_lsb
      assign lt_in = set_bit;
    end else begin : g_upper
      assign lt_in = 1'b0;
    end
    always_comb begin
      case (op)
        OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: y = sum[i];
        OP_AND:                           y = opa[i] & opb[i];
        OP_OR:                            y = opa[i] | opb[i];
        OP_XOR:                           y = opa[i] ^ opb[i];
        OP_NOR:                           y = ~(opa[i] | opb[i]);
        OP_SLT, OP_SLTU:                  y = lt_in;
        default:                          y = 1'b0;
      endcase
    end
    assign res[i] = y;
  end

  assign ovf_raw = carry[WIDTH] ^ carry[MSB];
  assign less_s  = sum[MSB] ^ ovf_raw;
  assign less_u  = ~carry[WIDTH];
  assign set_bit = (op == OP_SLT) ? less_s : less_u;

  assign ovf  = ovf_raw & ((op == OP_ADD) | (op == OP_SUB));
  assign zero = ~|res;
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] res,
  input logic             zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!$isunknown({opa, opb, op})) begin
      if (op == 4'h0 || op == 4'h1)
        assert_sum_R1: assert (res == WIDTH'(opa + opb)) else $error("R1 sum mismatch");
      if (op == 4'h2 || op == 4'h3)
        assert_diff_R2: assert (res == WIDTH'(opa - opb)) else $error("R2 difference mismatch");
      if (op == 4'h0)
        assert_add_overflow_R3: assert (ovf == ((opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB])))
          else $error("R3 add overflow mismatch");
      if (op == 4'h2)
        assert_sub_overflow_R3: assert (ovf == ((opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB])))
          else $error("R3 subtract overflow mismatch");
      if (op != 4'h0 && op != 4'h2)
        assert_no_overflow_R4: assert (!ovf) else $error("R4 overflow on unsigned or logic op");
      if (op == 4'h7)
        assert_nor_R5: assert ((res | opa | opb) == {WIDTH{1'b1}} && (res & (opa | opb)) == '0)
          else $error("R5 nor mismatch");
      if (op == 4'hA)
        assert_slt_R6: assert (res == {{(WIDTH-1){1'b0}}, ($signed(opa) < $signed(opb))})
          else $error("R6 signed compare mismatch");
      if (op == 4'hB)
        assert_sltu_R7: assert (res == {{(WIDTH-1){1'b0}}, (opa < opb)})
          else $error("R7 unsigned compare mismatch");
      if (op == 4'h2 || op == 4'h3)
        assert_zero_eq_R8: assert (zero == (opa == opb)) else $error("R8 zero flag mismatch");
      if (op == 4'h8 || op == 4'h9 || op >= 4'hC)
        assert_unused_R9: assert (res == '0 && !ovf && zero) else $error("R9 unused selector active");
    end
  end
endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH)) u_int_alu_checker (
  .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  op = '0;
  logic [31:0] res;
  logic        zero, ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  int_alu #(.WIDTH(32)) u_int_alu (
    .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'h4, 4'h5, 4'h6, 4'h7: return "R5";
      4'hA: return "R6";
      4'hB: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] o,
                       output logic [31:0] r, output logic v);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t;
    v = 1'b0;
    case (o)
      4'h0, 4'h1: begin t = sa + sb; r = a + b;
        if (o == 4'h0) v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'h2, 4'h3: begin t = sa - sb; r = a - b;
        if (o == 4'h2) v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: r = (sa < sb) ? 32'd1 : 32'd0;
      4'hB: r = (longint'(a) < longint'(b)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: op=%h a=%h b=%h actual=%h expected=%h", tag, op, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] o);
    logic [31:0] er;
    logic ev;
    @(posedge clk);
    opa = a; opb = b; op = o;
    @(negedge clk);
    model(a, b, o, er, ev);
    check(req_of(o), res, er);
    check((o == 4'h0 || o == 4'h2) ? "R3" : "R4", {31'd0, ovf}, {31'd0, ev});
    check("R8", {31'd0, zero}, {31'd0, (er == 32'd0)});
  endtask

  localparam int NCORNER = 8;
  logic [31:0] corner [NCORNER] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                    32'h8000_0000, 32'h8000_0001, 32'hAAAA_AAAA, 32'h5555_5555};

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 initial state: zero operands, add selector
    check("R8", {31'd0, zero}, 32'd1);
    check("R1", res, 32'd0);
    // R3 directed: positive overflow on add, negative overflow on sub
    apply(32'h7FFF_FFFF, 32'h1, 4'h0);
    apply(32'h8000_0000, 32'h1, 4'h2);
    apply(32'h7FFF_FFFF, 32'h1, 4'h1);  // R4 unsigned add never flags
    // R6 slt where the difference overflows
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'hA);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 4'hA);
    // R7 unsigned extremes
    apply(32'h0, 32'hFFFF_FFFF, 4'hB);
    // R8 equal operands under subtraction
    apply(32'h1234_5678, 32'h1234_5678, 4'h3);
    // R9 unused selectors
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h8);
    apply(32'h8000_0000, 32'h8000_0000, 4'hF);
    // all selectors across corner operand pairs
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < NCORNER; x++)
        for (int y = 0; y < NCORNER; y++)
          apply(corner[x], corner[y], 4'(o));
    // random stream
    for (int n = 0; n < 4000; n++)
      apply($urandom, $urandom, 4'($urandom_range(0, 15)));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule